// File: doc/BRIEF.md
# Receive Ring Admission Controller

This block sits in front of a receive path and decides, one frame at a time, whether the frame may enter a circular ring of 16-byte receive descriptors. It owns the ring's head index, which it advances once for each descriptor a frame uses. Software owns the tail index, which it supplies through a tail-write strobe. Before the admission test, a short frame is padded to the Ethernet minimum, and a frame above the tagged-frame ceiling is refused unless either long frames or bad-frame storage is enabled.

A frame is offered through `frm_valid`/`frm_len` while `frm_ready` is high. A controller with five states handles it. In **IDLE** the controller captures the padded length. **MEASURE** counts how many buffers the frame needs, subtracting the buffer size once per cycle. **JUDGE** applies the oversize rule and the occupancy test. **TAKE** steps the head once per cycle for each descriptor used. **REPORT** presents the verdict for one cycle.

The state transitions are as follows:
- IDLE→MEASURE when a frame is offered.
- MEASURE→MEASURE while the remaining length is larger than one buffer.
- MEASURE→JUDGE otherwise.
- JUDGE→TAKE on admission.
- JUDGE→REPORT on refusal.
- TAKE→TAKE while more than one descriptor is left.
- TAKE→REPORT on the last descriptor.
- REPORT→IDLE.

A flush pulse tells the upstream queue that it may retry held frames.

Top module: `rx_ring_admit`

## Requirements
- R1: A frame whose padded length exceeds 1522 bytes is refused (`dec_accept`=0, head unchanged) unless `ctrl_long_en` or `ctrl_store_bad`, as last latched by `ctrl_wr`, is 1; this holds even when the ring has space.
- R2: A frame shorter than 60 bytes is handled as 60 bytes, and `dec_len` reports the padded length.
- R3: A frame whose padded length is at most one buffer is admitted exactly when head differs from tail.
- R4: A larger frame needs ceil(len/buffer) descriptors, reported on `dec_descs`. It is admitted when the free count is at least that number. The free count is tail−head when head<tail, ring_bytes/16+tail−head when head>tail, and 0 when they are equal.
- R5: An admitted frame advances the head by one per descriptor it uses. Each step goes to 0 instead of head+1 when (head+1)×16 ≥ ring_bytes. A refused frame leaves the head unchanged.
- R6: `tail_wr` stores only `tail_wdata[15:0]`. `flush_pulse` is 1 in the cycle after the write exactly when those 16 bits differ from the head.
- R7: `ctrl_wr` latches both control bits and makes `flush_pulse` 1 in the following cycle.
- R8: A `buf_bytes` value of 0 selects a 2048-byte buffer.
- R9: `dec_valid` is high for exactly one cycle per offered frame. `frm_ready` is low from the cycle after the offer until the cycle after the report.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset; head, tail and controls go to 0 |
| frm_valid | input | 1 | A frame is offered |
| frm_len | input | 16 | Frame length in bytes |
| frm_ready | output | 1 | Controller is idle and takes an offer |
| ring_bytes | input | 20 | Ring length in bytes |
| buf_bytes | input | 16 | Receive buffer size in bytes, 0 means 2048 |
| tail_wr | input | 1 | Tail write strobe |
| tail_wdata | input | 32 | Tail write data, low 16 bits kept |
| ctrl_wr | input | 1 | Receive control write strobe |
| ctrl_long_en | input | 1 | Long-frame enable, latched on `ctrl_wr` |
| ctrl_store_bad | input | 1 | Bad-frame storage enable, latched on `ctrl_wr` |
| dec_valid | output | 1 | Verdict valid for one cycle |
| dec_accept | output | 1 | 1 when the frame was admitted |
| dec_len | output | 16 | Padded length of the judged frame |
| dec_descs | output | 16 | Descriptors the frame needs |
| head_ptr | output | 16 | Current head index |
| flush_pulse | output | 1 | One-cycle space-available pulse |

## Verification
The hardest case to reach is a multi-descriptor frame whose TAKE sequence crosses the end of the ring while tail is numerically below head. That case needs the free count of the wrapped branch and several wrap steps in one burst. The stimulus gets there by moving the tail backwards with a tail write once the head has passed it. It then sends four-buffer frames until the head sits three descriptors from the end, and sends one more four-buffer frame. That frame must step through the last indices and land on zero.

// File: rtl/rx_adm_pkg.sv
package rx_adm_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_MEASURE,
        S_JUDGE,
        S_TAKE,
        S_REPORT
    } adm_state_e;

    localparam int MIN_FRAME_BYTES = 60;
    localparam int MAX_PLAIN_BYTES = 1522;
    localparam int DFLT_BUF_BYTES  = 2048;
endpackage

// File: rtl/rx_len_shaper.sv
module rx_len_shaper
    import rx_adm_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic [LEN_W-1:0] raw_len,
    input  logic             long_en,
    input  logic             store_bad,
    output logic [LEN_W-1:0] padded_len,
    output logic             oversize_drop
);
    localparam logic [LEN_W-1:0] MIN_LEN = LEN_W'(MIN_FRAME_BYTES);
    localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(MAX_PLAIN_BYTES);

    always_comb begin
        padded_len    = (raw_len < MIN_LEN) ? MIN_LEN : raw_len;
        oversize_drop = (padded_len > MAX_LEN) && !long_en && !store_bad;
    end

    always_comb begin
        AST_PAD_FLOOR: assert (padded_len >= MIN_LEN && padded_len >= raw_len); // R2
    end
endmodule

// File: rtl/rx_ring_space.sv
module rx_ring_space #(
    parameter int PTR_W      = 16,
    parameter int RING_W     = 20,
    parameter int DESC_SHIFT = 4
) (
    input  logic [PTR_W-1:0]  head,
    input  logic [PTR_W-1:0]  tail,
    input  logic [RING_W-1:0] ring_bytes,
    output logic [RING_W-1:0] free_cnt,
    output logic              not_empty
);
    localparam int SUM_W = (RING_W > PTR_W) ? RING_W + 1 : PTR_W + 1;

    logic [SUM_W-1:0] ring_descs;
    logic [SUM_W-1:0] head_x;
    logic [SUM_W-1:0] tail_x;

    always_comb begin
        ring_descs = SUM_W'(ring_bytes >> DESC_SHIFT);
        head_x     = SUM_W'(head);
        tail_x     = SUM_W'(tail);
        not_empty  = (head != tail);
        if (head < tail) begin
            free_cnt = RING_W'(tail_x - head_x);
        end else if (head > tail) begin
            free_cnt = RING_W'(ring_descs + tail_x - head_x);
        end else begin
            free_cnt = '0;
        end
    end
endmodule

// File: rtl/rx_head_ctr.sv
module rx_head_ctr #(
    parameter int PTR_W      = 16,
    parameter int RING_W     = 20,
    parameter int DESC_SHIFT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic [RING_W-1:0] ring_bytes,
    output logic [PTR_W-1:0]  head
);
    logic [PTR_W:0] head_inc;
    logic           wrap_now;

    always_comb begin
        head_inc = {1'b0, head} + 1'b1;
        wrap_now = ((64'(head_inc) << DESC_SHIFT) >= 64'(ring_bytes));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head <= '0;
        end else if (step) begin
            head <= wrap_now ? '0 : head_inc[PTR_W-1:0];
        end
    end

    AST_HEAD_STEP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (head == '0 || head == $past(head) + 1'b1)); // R5

    AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(head)); // R5
endmodule

// File: rtl/rx_ring_admit.sv
module rx_ring_admit
    import rx_adm_pkg::*;
#(
    parameter int LEN_W      = 16,
    parameter int PTR_W      = 16,
    parameter int RING_W     = 20,
    parameter int WDATA_W    = 32,
    parameter int DESC_SHIFT = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frm_valid,
    input  logic [LEN_W-1:0]   frm_len,
    output logic               frm_ready,
    input  logic [RING_W-1:0]  ring_bytes,
    input  logic [LEN_W-1:0]   buf_bytes,
    input  logic               tail_wr,
    input  logic [WDATA_W-1:0] tail_wdata,
    input  logic               ctrl_wr,
    input  logic               ctrl_long_en,
    input  logic               ctrl_store_bad,
    output logic               dec_valid,
    output logic               dec_accept,
    output logic [LEN_W-1:0]   dec_len,
    output logic [LEN_W-1:0]   dec_descs,
    output logic [PTR_W-1:0]   head_ptr,
    output logic               flush_pulse
);
    localparam logic [LEN_W-1:0] DFLT_BUF = LEN_W'(DFLT_BUF_BYTES);
    localparam int               CMP_W    = (RING_W > LEN_W) ? RING_W : LEN_W;

    adm_state_e state_q, state_d;

    logic [LEN_W-1:0] len_q;
    logic [LEN_W:0]   rem_q;
    logic [LEN_W-1:0] need_q;
    logic [LEN_W-1:0] take_q;
    logic             over_q;
    logic             acc_q;
    logic             long_q;
    logic             bad_q;
    logic [PTR_W-1:0] tail_q;
    logic             flush_q;

    logic [LEN_W-1:0]  eff_buf;
    logic [LEN_W-1:0]  padded_len;
    logic              oversize_drop;
    logic [RING_W-1:0] free_cnt;
    logic              not_empty;
    logic              more_bufs;
    logic              admit_ok;
    logic              head_step;
    logic              unused_tail_hi;

    assign unused_tail_hi = ^tail_wdata[WDATA_W-1:PTR_W];
    assign eff_buf        = (buf_bytes == '0) ? DFLT_BUF : buf_bytes;

    rx_len_shaper #(.LEN_W(LEN_W)) u_shaper (
        .raw_len       (frm_len),
        .long_en       (long_q),
        .store_bad     (bad_q),
        .padded_len    (padded_len),
        .oversize_drop (oversize_drop)
    );

    rx_ring_space #(
        .PTR_W(PTR_W), .RING_W(RING_W), .DESC_SHIFT(DESC_SHIFT)
    ) u_space (
        .head       (head_ptr),
        .tail       (tail_q),
        .ring_bytes (ring_bytes),
        .free_cnt   (free_cnt),
        .not_empty  (not_empty)
    );

    rx_head_ctr #(
        .PTR_W(PTR_W), .RING_W(RING_W), .DESC_SHIFT(DESC_SHIFT)
    ) u_head (
        .clk        (clk),
        .rst_n      (rst_n),
        .step       (head_step),
        .ring_bytes (ring_bytes),
        .head       (head_ptr)
    );

    always_comb begin
        more_bufs = (rem_q > {1'b0, eff_buf});
        if (over_q) begin
            admit_ok = 1'b0;
        end else if (len_q <= eff_buf) begin
            admit_ok = not_empty;
        end else begin
            admit_ok = (CMP_W'(free_cnt) >= CMP_W'(need_q));
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (frm_valid) state_d = S_MEASURE;
            S_MEASURE: if (!more_bufs) state_d = S_JUDGE;
            S_JUDGE:   state_d = admit_ok ? S_TAKE : S_REPORT;
            S_TAKE:    if (take_q == LEN_W'(1)) state_d = S_REPORT;
            S_REPORT:  state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    // Datapath and registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q   <= '0;
            rem_q   <= '0;
            need_q  <= '0;
            take_q  <= '0;
            over_q  <= 1'b0;
            acc_q   <= 1'b0;
            long_q  <= 1'b0;
            bad_q   <= 1'b0;
            tail_q  <= '0;
            flush_q <= 1'b0;
        end else begin
            flush_q <= ctrl_wr ||
                       (tail_wr && (tail_wdata[PTR_W-1:0] != head_ptr));
            if (ctrl_wr) begin
                long_q <= ctrl_long_en;
                bad_q  <= ctrl_store_bad;
            end
            if (tail_wr) begin
                tail_q <= tail_wdata[PTR_W-1:0];
            end
            unique case (state_q)
                S_IDLE: begin
                    if (frm_valid) begin
                        len_q  <= padded_len;
                        rem_q  <= {1'b0, padded_len};
                        need_q <= LEN_W'(1);
                        over_q <= oversize_drop;
                        acc_q  <= 1'b0;
                    end
                end
                S_MEASURE: begin
                    if (more_bufs) begin
                        rem_q  <= rem_q - {1'b0, eff_buf};
                        need_q <= need_q + 1'b1;
                    end
                end
                S_JUDGE: begin
                    acc_q  <= admit_ok;
                    take_q <= need_q;
                end
                S_TAKE: begin
                    take_q <= take_q - 1'b1;
                end
                S_REPORT: begin
                    take_q <= '0;
                end
                default: begin
                    take_q <= '0;
                end
            endcase
        end
    end

    assign head_step   = (state_q == S_TAKE);
    assign frm_ready   = (state_q == S_IDLE);
    assign dec_valid   = (state_q == S_REPORT);
    assign dec_accept  = acc_q;
    assign dec_len     = len_q;
    assign dec_descs   = need_q;
    assign flush_pulse = flush_q;

    AST_CTRL_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> flush_pulse); // R7

    AST_REPORT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |=> (!dec_valid && frm_ready)); // R9

    AST_EMPTY_RING_REJECTS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_JUDGE && head_ptr == tail_q) |=> (dec_valid && !dec_accept)); // R3

    AST_OFFER_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_ready && frm_valid) |=> !frm_ready); // R9
endmodule

// File: tb/rx_ring_admit_test.sv
`timescale 1ns/1ps
module rx_ring_admit_test;
    typedef struct packed {
        logic        accept;
        logic [15:0] len;
        logic [15:0] descs;
        logic [15:0] head;
        int unsigned rq;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frm_valid = 1'b0;
    logic [15:0] frm_len = '0;
    logic        frm_ready;
    logic [19:0] ring_bytes = 20'd256;
    logic [15:0] buf_bytes = 16'd512;
    logic        tail_wr = 1'b0;
    logic [31:0] tail_wdata = '0;
    logic        ctrl_wr = 1'b0;
    logic        ctrl_long_en = 1'b0;
    logic        ctrl_store_bad = 1'b0;
    logic        dec_valid;
    logic        dec_accept;
    logic [15:0] dec_len;
    logic [15:0] dec_descs;
    logic [15:0] head_ptr;
    logic        flush_pulse;

    int   n_cmp = 0;
    int   n_bad = 0;
    exp_t sb_q[$];
    int   m_head = 0;
    int   m_tail = 0;
    bit   m_long = 0;
    bit   m_bad = 0;

    always #4 clk = ~clk;

    rx_ring_admit uut (
        .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_len(frm_len),
        .frm_ready(frm_ready), .ring_bytes(ring_bytes), .buf_bytes(buf_bytes),
        .tail_wr(tail_wr), .tail_wdata(tail_wdata), .ctrl_wr(ctrl_wr),
        .ctrl_long_en(ctrl_long_en), .ctrl_store_bad(ctrl_store_bad),
        .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_len(dec_len),
        .dec_descs(dec_descs), .head_ptr(head_ptr), .flush_pulse(flush_pulse)
    );

    task automatic check(input bit ok, input string rq, input string what,
                         input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard on every verdict
    always @(negedge clk) begin
        if (rst_n && dec_valid) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R9", "unexpected verdict", 1, 0);
            end else begin
                exp_t e;
                string rq;
                e  = sb_q.pop_front();
                rq = $sformatf("R%0d", e.rq);
                check(dec_accept == e.accept, rq, "accept", dec_accept, e.accept);
                check(dec_len == e.len, "R2", "length", dec_len, e.len);
                check(dec_descs == e.descs, "R4", "descriptors", dec_descs, e.descs);
                check(head_ptr == e.head, "R5", "head", head_ptr, e.head);
            end
        end
    end

    // Driver: computes the expected verdict and offers the frame
    task automatic send(input int len, input int rq);
        exp_t e;
        int plen, bsz, need, freec;
        bit over, ok;
        plen  = (len < 60) ? 60 : len;
        bsz   = (buf_bytes == 0) ? 2048 : int'(buf_bytes);
        need  = (plen + bsz - 1) / bsz;
        over  = (plen > 1522) && !m_long && !m_bad;
        freec = (m_head < m_tail) ? m_tail - m_head :
                (m_head > m_tail) ? int'(ring_bytes) / 16 + m_tail - m_head : 0;
        if (over) ok = 0;
        else if (plen <= bsz) ok = (m_head != m_tail);
        else ok = (freec >= need);
        if (ok) begin
            for (int i = 0; i < need; i++) begin
                m_head = ((m_head + 1) * 16 >= int'(ring_bytes)) ? 0 : m_head + 1;
            end
        end
        e.accept = ok;
        e.len    = 16'(plen);
        e.descs  = 16'(need);
        e.head   = 16'(m_head);
        e.rq     = rq;
        sb_q.push_back(e);
        @(negedge clk);
        frm_valid = 1'b1;
        frm_len   = 16'(len);
        @(negedge clk);
        frm_valid = 1'b0;
        check(frm_ready == 1'b0, "R9", "ready after offer", frm_ready, 0);
        while (!frm_ready) @(negedge clk);
        check(dec_valid == 1'b0, "R9", "verdict width", dec_valid, 0);
        check(sb_q.size() == 0, "R9", "verdict missing", sb_q.size(), 0);
    endtask

    task automatic write_tail(input logic [31:0] val, input string rq);
        bit exp_fl;
        @(negedge clk);
        tail_wr    = 1'b1;
        tail_wdata = val;
        exp_fl     = (int'(val[15:0]) != m_head);
        m_tail     = int'(val[15:0]);
        @(negedge clk);
        tail_wr = 1'b0;
        check(flush_pulse == exp_fl, rq, "flush after tail write", flush_pulse, exp_fl);
    endtask

    task automatic write_ctrl(input bit lng, input bit bad);
        @(negedge clk);
        ctrl_wr        = 1'b1;
        ctrl_long_en   = lng;
        ctrl_store_bad = bad;
        m_long = lng;
        m_bad  = bad;
        @(negedge clk);
        ctrl_wr = 1'b0;
        check(flush_pulse == 1'b1, "R7", "flush after control write", flush_pulse, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "R9", "watchdog expired", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(head_ptr == 0, "R5", "reset head", head_ptr, 0);
        check(frm_ready == 1, "R9", "reset ready", frm_ready, 1);
        check(dec_valid == 0, "R9", "reset verdict", dec_valid, 0);
        check(flush_pulse == 0, "R6", "reset flush", flush_pulse, 0);

        send(100, 3);                 // R3: empty ring refuses
        write_tail(32'h0001_0005, "R6"); // R6: low 16 bits kept, tail 5
        send(40, 2);                  // R2: padded to 60, admitted
        send(1300, 4);                // R4: needs 3 of 4 free
        send(1600, 1);                // R1: oversize refused
        write_ctrl(1'b1, 1'b0);       // R7
        send(1600, 4);                // R4: needs 4, only 1 free
        write_tail(32'd3, "R6");      // tail behind head
        send(2000, 4);                // R4: wrapped free count, admit
        send(2048, 4);                // head to 12
        send(2048, 5);                // R5: steps through wrap to 0
        write_tail(32'd0, "R6");      // equal to head: no flush
        write_tail(32'h0001_0000, "R6"); // R6: upper bits ignored, no flush
        buf_bytes = 16'd0;            // R8: default 2048
        write_tail(32'd2, "R6");
        send(2048, 8);                // R8: one buffer, admitted
        send(2049, 8);                // R8: needs 2, only 1 free
        write_ctrl(1'b0, 1'b0);
        send(1600, 1);                // R1: refused despite space
        write_ctrl(1'b0, 1'b1);
        send(1600, 1);                // R1: store-bad permits it
        send(60, 3);                  // R3: head == tail now, refused
        repeat (4) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule